// File: doc/BRIEF.md
# Prescaled 54-bit Alarm Timer

This block is a 54-bit time base for general use. A programmable 16-bit divider turns the system clock into count ticks. On each tick the counter steps up or down by one. The counter is checked against a 54-bit alarm value, and a match raises an interrupt. When an alarm fires, the counter can reload itself from a programmed 54-bit reload value. After each alarm the alarm must be re-armed by software.

Software works through a small register file with one write strobe and a combinational read port. It sets up the control word, the alarm value and the reload value in 32-bit halves. The live counter cannot be read directly. A write to the snapshot register copies it into a readable pair of words. Another write forces an immediate reload. The interrupt has raw, enable, masked-status and write-one-to-clear bits. The whole block runs on one clock, with an active-low asynchronous reset.

Top module: `alarm_timer54`

## Requirements
- R1: Register map by word address. 0 is control: bit0 run, bit1 count up, bit2 auto-reload, bit3 alarm armed, bit4 divider-clear strobe (reads 0), bits 31:16 divide value. 1 and 2 are the snapshot low and high words. 3 takes a snapshot. 4 and 5 are the alarm low and high words. 6 and 7 are the reload low and high words. 8 forces a reload. 9 is the interrupt enable. 10 is the raw bit. 11 is the masked status. 12 is the clear register. Interrupt fields use bit0. After reset, control reads 0x0001_0006 and every other readable register reads 0, as does the irq pin.
- R2: While run is 1 and the divide value is N (1..65535), the counter takes one step every N clock cycles. A divide value of 0 divides by 65536.
- R3: Writing control with bit4 set clears the divider's internal count, so the next step comes a full N running cycles later.
- R4: With count up set, each step adds 1. With it cleared, each step subtracts 1. Both wrap modulo 2^54.
- R5: While run is 0, the counter keeps its value.
- R6: On a step that finds the alarm armed, the alarm fires when the counter is greater than or equal to the alarm value (counting up) or less than or equal to it (counting down). The armed bit then clears itself.
- R7: When an alarm fires with auto-reload set, the counter takes the reload value instead of stepping. With auto-reload clear, it steps normally.
- R8: A write to address 3 copies the counter into the snapshot words. If a step happens in the same cycle, the copy holds the value from before that step. The snapshot words change at no other time.
- R9: A write to address 8 loads the counter with the reload value at once. This takes priority over a step in the same cycle.
- R10: A fired alarm sets the raw bit. The masked status and the irq pin equal raw AND enable. Writing 1 to bit0 of address 12 clears raw, and writing 0 there has no effect. A new alarm wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data, combinational from registers |
| irq | output | 1 | Masked alarm interrupt |

## Verification
Some behaviours are checked by the assertions on every cycle:
- A step only moves the counter by one in the chosen direction, and the counter stays still without a step or load.
- A forced load or an auto-reload puts the reload value in the counter on the next edge.
- A firing alarm disarms itself and sets the raw bit.
- The divider count restarts after a clear strobe.
- The snapshot never changes without a snapshot write.

Other behaviours only the bench scenarios can show. These include the exact step spacing for each divide value, including divide-by-65536, and wrap-around across the 32-bit word boundary and at both ends of the range. They also include the greater-or-equal rule when the alarm value has already been passed, and whether the snapshot holds the value from before or after a step.

// File: rtl/atm_pkg.sv
package atm_pkg;
  localparam int unsigned ATM_CNT_W  = 54;
  localparam int unsigned ATM_PSC_W  = 16;
  localparam int unsigned ATM_ADDR_W = 4;
  localparam int unsigned ATM_DATA_W = 32;

  typedef enum logic [ATM_ADDR_W-1:0] {
    A_CTRL     = 4'd0,
    A_SNAP_LO  = 4'd1,
    A_SNAP_HI  = 4'd2,
    A_SNAP_TAKE= 4'd3,
    A_ALM_LO   = 4'd4,
    A_ALM_HI   = 4'd5,
    A_RLD_LO   = 4'd6,
    A_RLD_HI   = 4'd7,
    A_RLD_NOW  = 4'd8,
    A_IRQ_EN   = 4'd9,
    A_IRQ_RAW  = 4'd10,
    A_IRQ_STAT = 4'd11,
    A_IRQ_CLR  = 4'd12
  } atm_addr_e;

  localparam int unsigned CB_RUN     = 0;
  localparam int unsigned CB_UP      = 1;
  localparam int unsigned CB_AUTO    = 2;
  localparam int unsigned CB_ARM     = 3;
  localparam int unsigned CB_DCLR    = 4;
  localparam int unsigned CB_PSC_LSB = 16;
endpackage

// File: rtl/atm_prescaler.sv
module atm_prescaler #(
  parameter int unsigned PSC_W = atm_pkg::ATM_PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  localparam logic [PSC_W-1:0] ONE = {{(PSC_W-1){1'b0}}, 1'b1};

  // Last divider count before a tick; 0 selects the full 2^PSC_W divide.
  function automatic logic [PSC_W-1:0] last_count(input logic [PSC_W-1:0] d);
    return (d == '0) ? {PSC_W{1'b1}} : d - ONE;
  endfunction

  logic [PSC_W-1:0] divcnt;
  logic             at_last;

  assign at_last = (divcnt == last_count(div));
  assign tick    = run && !clear && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       divcnt <= '0;
    else if (clear)   divcnt <= '0;
    else if (tick)    divcnt <= '0;
    else if (run)     divcnt <= divcnt + ONE;
  end

  a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (divcnt == '0));
  a_r2_divider_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && !tick) |=> (divcnt == $past(divcnt) + ONE));
  a_r5_divider_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(divcnt));
endmodule

// File: rtl/atm_counter.sv
module atm_counter #(
  parameter int unsigned CNT_W = atm_pkg::ATM_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             up,
  input  logic             arm,
  input  logic             autoreload,
  input  logic [CNT_W-1:0] alarm_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v, input logic dir_up);
    return dir_up ? v + ONE : v - ONE;
  endfunction

  function automatic logic hit(input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] a,
                               input logic dir_up);
    return dir_up ? (v >= a) : (v <= a);
  endfunction

  logic reached;
  assign reached = hit(count, alarm_val, up);
  assign fire    = tick && arm && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (load)                  count <= reload_val;
    else if (fire && autoreload)    count <= reload_val;
    else if (tick)                  count <= step(count, up);
  end

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(reload_val)));
  a_r7_auto_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && autoreload) |=> (count == $past(reload_val)));
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && up && !fire && !load) |=> (count == $past(count) + ONE));
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !up && !fire && !load) |=> (count == $past(count) - ONE));
  a_r6_fire_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (tick && arm));
endmodule

// File: rtl/atm_regs.sv
module atm_regs
  import atm_pkg::*;
#(
  parameter int unsigned CNT_W  = ATM_CNT_W,
  parameter int unsigned PSC_W  = ATM_PSC_W,
  parameter int unsigned ADDR_W = ATM_ADDR_W,
  parameter int unsigned DATA_W = ATM_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  count,
  input  logic              fire,
  output logic              run,
  output logic              up,
  output logic              autoreload,
  output logic              arm,
  output logic              div_clear,
  output logic [PSC_W-1:0]  div,
  output logic [CNT_W-1:0]  alarm_val,
  output logic [CNT_W-1:0]  reload_val,
  output logic              load_now,
  output logic              irq
);
  localparam int unsigned HI_W  = CNT_W - DATA_W;
  localparam int unsigned PAD_W = DATA_W - HI_W;
  localparam logic [PSC_W-1:0] PSC_RST = {{(PSC_W-1){1'b0}}, 1'b1};

  logic             ctrl_wr, take_wr, clr_wr;
  logic [CNT_W-1:0] snap;
  logic             irq_en, irq_raw;

  function automatic logic is_wr(input logic en, input logic [ADDR_W-1:0] a,
                                 input atm_addr_e target);
    return en && (a == target);
  endfunction

  assign ctrl_wr   = is_wr(wr_en, wr_addr, A_CTRL);
  assign take_wr   = is_wr(wr_en, wr_addr, A_SNAP_TAKE);
  assign clr_wr    = is_wr(wr_en, wr_addr, A_IRQ_CLR);
  assign load_now  = is_wr(wr_en, wr_addr, A_RLD_NOW);
  assign div_clear = ctrl_wr && wr_data[CB_DCLR];
  assign irq       = irq_raw && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; up <= 1'b1; autoreload <= 1'b1; div <= PSC_RST;
    end else if (ctrl_wr) begin
      run        <= wr_data[CB_RUN];
      up         <= wr_data[CB_UP];
      autoreload <= wr_data[CB_AUTO];
      div        <= wr_data[CB_PSC_LSB +: PSC_W];
    end
  end

  // Software write of the control word takes priority over the self-clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arm <= 1'b0;
    else if (ctrl_wr) arm <= wr_data[CB_ARM];
    else if (fire)    arm <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_val <= '0; reload_val <= '0; irq_en <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_ALM_LO: alarm_val[DATA_W-1:0]      <= wr_data;
        A_ALM_HI: alarm_val[CNT_W-1:DATA_W]  <= wr_data[HI_W-1:0];
        A_RLD_LO: reload_val[DATA_W-1:0]     <= wr_data;
        A_RLD_HI: reload_val[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
        A_IRQ_EN: irq_en                     <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap <= '0;
    else if (take_wr) snap <= count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     irq_raw <= 1'b0;
    else if (fire)                  irq_raw <= 1'b1;
    else if (clr_wr && wr_data[0])  irq_raw <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[CB_RUN]               = run;
        rd_data[CB_UP]                = up;
        rd_data[CB_AUTO]              = autoreload;
        rd_data[CB_ARM]               = arm;
        rd_data[CB_PSC_LSB +: PSC_W]  = div;
      end
      A_SNAP_LO:  rd_data = snap[DATA_W-1:0];
      A_SNAP_HI:  rd_data = {{PAD_W{1'b0}}, snap[CNT_W-1:DATA_W]};
      A_ALM_LO:   rd_data = alarm_val[DATA_W-1:0];
      A_ALM_HI:   rd_data = {{PAD_W{1'b0}}, alarm_val[CNT_W-1:DATA_W]};
      A_RLD_LO:   rd_data = reload_val[DATA_W-1:0];
      A_RLD_HI:   rd_data = {{PAD_W{1'b0}}, reload_val[CNT_W-1:DATA_W]};
      A_IRQ_EN:   rd_data[0] = irq_en;
      A_IRQ_RAW:  rd_data[0] = irq_raw;
      A_IRQ_STAT: rd_data[0] = irq;
      default:    rd_data = '0;
    endcase
  end

  a_r6_arm_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctrl_wr) |=> !arm);
  a_r10_raw_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq_raw);
  a_r10_clear_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wr_data[0] && !fire) |=> !irq_raw);
  a_r8_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !take_wr |=> $stable(snap));
  a_r8_snap_pre_tick: assert property (@(posedge clk) disable iff (!rst_n)
    take_wr |=> (snap == $past(count)));
endmodule

// File: rtl/alarm_timer54.sv
module alarm_timer54
  import atm_pkg::*;
#(
  parameter int unsigned CNT_W  = ATM_CNT_W,
  parameter int unsigned PSC_W  = ATM_PSC_W,
  parameter int unsigned ADDR_W = ATM_ADDR_W,
  parameter int unsigned DATA_W = ATM_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic             run, up, autoreload, arm, div_clear, load_now;
  logic             tick, fire;
  logic [PSC_W-1:0] div;
  logic [CNT_W-1:0] alarm_val, reload_val, count;

  atm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .count(count), .fire(fire),
    .run(run), .up(up), .autoreload(autoreload), .arm(arm), .div_clear(div_clear),
    .div(div), .alarm_val(alarm_val), .reload_val(reload_val), .load_now(load_now),
    .irq(irq)
  );

  atm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(div_clear), .div(div), .tick(tick)
  );

  atm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load_now), .up(up), .arm(arm),
    .autoreload(autoreload), .alarm_val(alarm_val), .reload_val(reload_val),
    .count(count), .fire(fire)
  );

  a_r2_tick_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);
endmodule

// File: tb/alarm_timer54_tb.sv
`timescale 1ns/1ps
module alarm_timer54_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam logic [53:0] MASK54 = {54{1'b1}};

  typedef struct packed {
    logic [15:0] psc;
    logic        up;
    logic [31:0] n;
    logic [53:0] start;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'd1, 1'b1, 32'd10, 54'd0},
    '{16'd3, 1'b1, 32'd10, 54'd100},
    '{16'd1, 1'b0, 32'd5,  54'd2},
    '{16'd4, 1'b0, 32'd9,  54'd1000},
    '{16'd1, 1'b1, 32'd3,  54'h3F_FFFF_FFFF_FFFE},
    '{16'd2, 1'b1, 32'd7,  54'h0_FFFF_FFFF}
  };

  always #2 clk = ~clk;

  alarm_timer54 u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [31:0] cw(input bit run, input bit up, input bit au,
                                     input bit arm, input bit dclr, input logic [15:0] psc);
    return {psc, 11'd0, dclr, arm, au, up, run};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  task automatic snap(output logic [53:0] v);
    logic [31:0] lo, hi;
    wr(4'd3, 32'd0);
    rd(4'd1, lo); rd(4'd2, hi);
    v = {hi[21:0], lo};
  endtask

  task automatic read_snap_only(output logic [53:0] v);
    logic [31:0] lo, hi;
    rd(4'd1, lo); rd(4'd2, hi);
    v = {hi[21:0], lo};
  endtask

  task automatic set_reload(input logic [53:0] v);
    wr(4'd6, v[31:0]); wr(4'd7, {10'd0, v[53:32]});
  endtask

  task automatic set_alarm(input logic [53:0] v);
    wr(4'd4, v[31:0]); wr(4'd5, {10'd0, v[53:32]});
  endtask

  // Run for n clock edges: counting is live from the enabling edge through the stopping edge.
  task automatic run_n(input bit up, input bit au, input bit arm, input logic [15:0] psc, input int n);
    wr(4'd0, cw(1, up, au, arm, 0, psc));
    idle(n - 1);
    wr(4'd0, cw(0, up, au, 0, 0, psc));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [53:0] v, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, r); chk("R1 ctrl reset", r, 32'h0001_0006);
    rd(4'd1, r); chk("R1 snap lo reset", r, 0);
    rd(4'd2, r); chk("R1 snap hi reset", r, 0);
    rd(4'd10, r); chk("R1 raw reset", r, 0);
    chk("R1 irq pin reset", irq, 0);

    // Vector table: R2 divide, R4 direction and wrap
    for (int i = 0; i < NV; i++) begin
      logic [53:0] steps;
      wr(4'd0, cw(0, VECS[i].up, 0, 0, 1, VECS[i].psc));
      set_reload(VECS[i].start);
      wr(4'd8, 32'd0);
      run_n(VECS[i].up, 0, 0, VECS[i].psc, int'(VECS[i].n));
      steps = 54'(VECS[i].n / ((VECS[i].psc == 0) ? 32'd65536 : 32'(VECS[i].psc)));
      e = VECS[i].up ? (VECS[i].start + steps) & MASK54 : (VECS[i].start - steps) & MASK54;
      snap(v);
      chk($sformatf("R2 R4 vector %0d", i), v, e);
    end

    // R5 hold while stopped
    set_reload(54'd77); wr(4'd8, 32'd0);
    idle(20);
    snap(v); chk("R5 counter held while stopped", v, 54'd77);

    // R3 divider clear
    wr(4'd0, cw(0, 1, 0, 0, 1, 16'd4));
    set_reload(54'd0); wr(4'd8, 32'd0);
    run_n(1, 0, 0, 16'd4, 3);
    wr(4'd0, cw(0, 1, 0, 0, 1, 16'd4));
    run_n(1, 0, 0, 16'd4, 3);
    snap(v); chk("R3 divider cleared before resume", v, 54'd0);

    // R2 divide value 0 means 65536
    wr(4'd0, cw(0, 1, 0, 0, 1, 16'd0));
    wr(4'd8, 32'd0);
    run_n(1, 0, 0, 16'd0, 65535);
    snap(v); chk("R2 divide 0 no step before 65536", v, 54'd0);
    wr(4'd0, cw(0, 1, 0, 0, 1, 16'd0));
    run_n(1, 0, 0, 16'd0, 65536);
    snap(v); chk("R2 divide 0 one step at 65536", v, 54'd1);

    // R8 snapshot in a step cycle holds the pre-step value
    wr(4'd0, cw(0, 1, 0, 0, 1, 16'd1));
    set_reload(54'd0); wr(4'd8, 32'd0);
    wr(4'd0, cw(1, 1, 0, 0, 0, 16'd1));
    idle(4);
    wr(4'd3, 32'd0);
    wr(4'd0, cw(0, 1, 0, 0, 0, 16'd1));
    read_snap_only(v); chk("R8 snapshot pre-step value", v, 54'd4);
    idle(3);
    read_snap_only(v); chk("R8 snapshot unchanged without take", v, 54'd4);
    snap(v); chk("R8 fresh snapshot", v, 54'd6);

    // R9 load during running beats the step
    set_reload(54'd0); wr(4'd8, 32'd0);
    wr(4'd0, cw(1, 1, 0, 0, 0, 16'd1));
    idle(2);
    wr(4'd6, 32'd100);
    wr(4'd8, 32'd0);
    wr(4'd0, cw(0, 1, 0, 0, 0, 16'd1));
    snap(v); chk("R9 load priority", v, 54'd101);

    // R6 R7 R10 up alarm with auto-reload
    wr(4'd9, 32'd1);
    set_reload(54'd5); wr(4'd8, 32'd0);
    set_alarm(54'd8);
    wr(4'd0, cw(1, 1, 1, 1, 1, 16'd1));
    idle(5);
    rd(4'd0, r); chk("R6 armed bit self-cleared", r[3], 0);
    chk("R10 irq pin raised", irq, 1);
    wr(4'd0, cw(0, 1, 1, 0, 0, 16'd1));
    snap(v); chk("R7 auto-reload on alarm", v, 54'd7);
    rd(4'd11, r); chk("R10 masked status", r, 1);
    wr(4'd12, 32'd0);
    rd(4'd10, r); chk("R10 clear with 0 ignored", r, 1);
    wr(4'd12, 32'd1);
    rd(4'd10, r); chk("R10 raw cleared", r, 0);
    chk("R10 irq pin cleared", irq, 0);

    // R7 without auto-reload, up
    set_reload(54'd5); wr(4'd8, 32'd0);
    wr(4'd0, cw(1, 1, 0, 1, 1, 16'd1));
    idle(5);
    rd(4'd0, r); chk("R6 armed bit cleared no reload", r[3], 0);
    wr(4'd0, cw(0, 1, 0, 0, 0, 16'd1));
    snap(v); chk("R7 no reload keeps stepping", v, 54'd11);
    rd(4'd10, r); chk("R10 raw set", r, 1);
    wr(4'd12, 32'd1);

    // R6 down alarm, interrupt masked
    wr(4'd9, 32'd0);
    set_reload(54'd20); wr(4'd8, 32'd0);
    set_alarm(54'd17);
    run_n(0, 0, 1, 16'd1, 5);
    snap(v); chk("R6 down alarm count", v, 54'd15);
    rd(4'd10, r); chk("R6 down alarm fired raw", r, 1);
    chk("R10 irq masked by enable", irq, 0);
    rd(4'd11, r); chk("R10 masked status zero", r, 0);
    wr(4'd12, 32'd1);

    // R6 alarm value already passed fires on first step
    set_reload(54'd50); wr(4'd8, 32'd0);
    set_reload(54'd3);
    set_alarm(54'd10);
    run_n(1, 1, 1, 16'd1, 2);
    snap(v); chk("R6 ge rule fires at once", v, 54'd4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule